// File: doc/BRIEF.md
# Write-Masked Programmable Clock Divider

This block divides its input clock by a ratio taken from a field of a 32-bit control register. Software updates the register without reading it first. Each write carries the new bit values in the low half-word and, in the high half-word, one enable bit for each of those low bits. Only the low bits whose enable is set take the written value. Reads return the stored low half-word. Nothing is stored for the enable half.

The divide field sits at a parameterised position and width inside the low half-word. Three encodings can be chosen at elaboration. In the default encoding the ratio is the field value plus one. In the one-based encoding the ratio equals the field value. In the power-of-two encoding the ratio is two to the power of the field value. A ratio of one means bypass: the output follows the input clock. When the control register changes, the new ratio is loaded only when the current output period ends, so no short pulse can appear.

Top module: `wmask_clkdiv`

## Requirements
- R1: On a write, low bit i (0..15) of the register takes write-data bit i when write-data bit i+16 is 1, and otherwise keeps its value.
- R2: A write whose bits [31:16] are all zero leaves the register unchanged.
- R3: The read port returns the stored register in [15:0] and zero in [31:16], and the value is visible on the cycle after the write edge.
- R4: A synchronous active-low reset clears the register to zero and restarts the counter, so the output follows the input clock (ratio one) after reset.
- R5: With the default encoding, the divide ratio is the field value plus one.
- R6: With the one-based encoding, the divide ratio equals the field value.
- R7: With the power-of-two encoding, the divide ratio is 2 raised to the field value. For example, with a 2-bit field at shift 0, write data 0x0003_0001 selects ratio 2.
- R8: With the one-based encoding and zero allowed, a field value of zero selects bypass. With zero not allowed, a zero field is ignored and the previous ratio stays in force.
- R9: For a ratio N of 2 or more, the output is high for floor(N/2) input cycles and low for the rest of each N-cycle period.
- R10: A changed ratio takes effect only at the end of the output period in progress. The period during which the write happens keeps the old length.
- R11: Only the bits at positions SHIFT..SHIFT+WIDTH-1 affect the ratio. A configuration with SHIFT+WIDTH above 16 stops elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock, also the register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Values in [15:0], per-bit enables in [31:16] |
| bus_rdata | output | 32 | Stored value in [15:0], zero in [31:16] |
| clk_out | output | 1 | Divided clock, or the input clock when the ratio is one |

## Verification
The assertions assume that the write strobe and write data are driven synchronously to the input clock and are stable around its rising edge. They also assume that reset is held low at time zero. The bench drives every input a short delay after a rising edge and starts with reset asserted, so both assumptions hold. The period-length assertions also assume that any field value the encoding decodes as valid gives a ratio of at least one. The bench writes only such values, apart from the deliberately ignored zero in the one-based mode without bypass.

// File: rtl/wmclk_pkg.sv
package wmclk_pkg;

    localparam int unsigned HALF_W = 16;
    localparam int unsigned REG_W  = 2 * HALF_W;

    typedef enum logic [1:0] {
        DIV_PLUS_ONE  = 2'd0,
        DIV_ONE_BASED = 2'd1,
        DIV_POW2      = 2'd2
    } div_enc_e;

    // Bits needed to hold the largest ratio a field of 'width' bits can select.
    function automatic int unsigned ratio_bits(div_enc_e enc, int unsigned width);
        if (enc == DIV_POW2) begin
            return (2 ** width);
        end
        return width + 1;
    endfunction

endpackage

// File: rtl/wmclk_maskreg.sv
module wmclk_maskreg #(
    parameter int unsigned HALF_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [2*HALF_W-1:0]   wdata,
    output logic [HALF_W-1:0]     value
);

    typedef struct packed {
        logic [HALF_W-1:0] bits;
    } reg_state_t;

    reg_state_t st_q, st_d;
    logic [HALF_W-1:0] merged;

    // One enable per stored bit: bit i listens to enable i+HALF_W.
    for (genvar i = 0; i < HALF_W; i++) begin : g_bit
        assign merged[i] = wdata[i + HALF_W] ? wdata[i] : st_q.bits[i];
    end

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.bits = merged;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign value = st_q.bits;

endmodule

// File: rtl/wmclk_decode.sv
module wmclk_decode
    import wmclk_pkg::*;
#(
    parameter int unsigned HALF_W      = 16,
    parameter int unsigned SHIFT       = 0,
    parameter int unsigned WIDTH       = 4,
    parameter div_enc_e    ENC         = DIV_PLUS_ONE,
    parameter bit          ZERO_BYPASS = 1'b1,
    parameter int unsigned RATIO_W     = 5
) (
    input  logic [HALF_W-1:0]  ctrl,
    output logic [RATIO_W-1:0] ratio,
    output logic               ratio_ok
);

    logic [WIDTH-1:0] field;
    assign field = ctrl[SHIFT +: WIDTH];

    if (ENC == DIV_POW2) begin : g_pow2
        assign ratio    = RATIO_W'(1) << field;
        assign ratio_ok = 1'b1;
    end else if (ENC == DIV_ONE_BASED) begin : g_one_based
        always_comb begin
            if (field == '0) begin
                ratio    = RATIO_W'(1);
                ratio_ok = ZERO_BYPASS;
            end else begin
                ratio    = RATIO_W'(field);
                ratio_ok = 1'b1;
            end
        end
    end else begin : g_plus_one
        assign ratio    = RATIO_W'(field) + RATIO_W'(1);
        assign ratio_ok = 1'b1;
    end

endmodule

// File: rtl/wmclk_divcnt.sv
module wmclk_divcnt #(
    parameter int unsigned RATIO_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] ratio_in,
    input  logic               ratio_ok,
    output logic [RATIO_W-1:0] ratio_act,
    output logic [RATIO_W-1:0] cnt_val,
    output logic               clk_out
);

    typedef struct packed {
        logic [RATIO_W-1:0] cnt;
        logic [RATIO_W-1:0] ratio;
        logic               div;
    } cnt_state_t;

    cnt_state_t st_q, st_d;
    logic       period_end;

    assign period_end = (st_q.cnt == st_q.ratio - RATIO_W'(1));

    always_comb begin
        st_d = st_q;
        if (period_end) begin
            st_d.cnt = '0;
            if (ratio_ok) begin
                st_d.ratio = ratio_in;
            end
        end else begin
            st_d.cnt = st_q.cnt + RATIO_W'(1);
        end
        st_d.div = (st_d.cnt < (st_d.ratio >> 1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt   <= '0;
            st_q.ratio <= RATIO_W'(1);
            st_q.div   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ratio_act = st_q.ratio;
    assign cnt_val   = st_q.cnt;
    assign clk_out   = (st_q.ratio == RATIO_W'(1)) ? clk : st_q.div;

endmodule

// File: rtl/wmask_clkdiv.sv
module wmask_clkdiv
    import wmclk_pkg::*;
#(
    parameter int unsigned SHIFT       = 0,
    parameter int unsigned WIDTH       = 4,
    parameter div_enc_e    ENC         = DIV_PLUS_ONE,
    parameter bit          ZERO_BYPASS = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_we,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        clk_out
);

    localparam int unsigned RATIO_W = ratio_bits(ENC, WIDTH);

    // R11: the field must lie wholly inside the stored half-word.
    if (SHIFT + WIDTH > HALF_W || WIDTH < 1) begin : g_cfg_bad
        $error("wmask_clkdiv: divide field does not fit in the low half-word");
    end

    logic [HALF_W-1:0]  ctrl;
    logic [RATIO_W-1:0] ratio_dec;
    logic               ratio_ok;
    logic [RATIO_W-1:0] ratio_act;
    logic [RATIO_W-1:0] cnt_val;

    wmclk_maskreg #(
        .HALF_W (HALF_W)
    ) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bus_we),
        .wdata (bus_wdata),
        .value (ctrl)
    );

    wmclk_decode #(
        .HALF_W      (HALF_W),
        .SHIFT       (SHIFT),
        .WIDTH       (WIDTH),
        .ENC         (ENC),
        .ZERO_BYPASS (ZERO_BYPASS),
        .RATIO_W     (RATIO_W)
    ) u_dec (
        .ctrl     (ctrl),
        .ratio    (ratio_dec),
        .ratio_ok (ratio_ok)
    );

    wmclk_divcnt #(
        .RATIO_W (RATIO_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .ratio_in  (ratio_dec),
        .ratio_ok  (ratio_ok),
        .ratio_act (ratio_act),
        .cnt_val   (cnt_val),
        .clk_out   (clk_out)
    );

    assign bus_rdata = {{(REG_W - HALF_W){1'b0}}, ctrl};

endmodule

// File: rtl/wmclk_checker.sv
module wmclk_checker #(
    parameter int unsigned RATIO_W = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_we,
    input logic [31:0]        bus_wdata,
    input logic [31:0]        bus_rdata,
    input logic [RATIO_W-1:0] ratio_act,
    input logic [RATIO_W-1:0] cnt_val
);

    // R1: enabled bits take the written value
    p_set_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |=> ((bus_rdata[15:0] & $past(bus_wdata[31:16]))
                    == ($past(bus_wdata[15:0]) & $past(bus_wdata[31:16]))));

    // R1: bits without enable keep their value
    p_keep_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |=> (((bus_rdata[15:0] ^ $past(bus_rdata[15:0]))
                     & ~$past(bus_wdata[31:16])) == 16'h0000));

    // R2: empty enable half-word changes nothing
    p_empty_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_wdata[31:16] == 16'h0000) |=> $stable(bus_rdata));

    // R3: no write, no change; upper read half is zero
    p_idle_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(bus_rdata));

    p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[31:16] == 16'h0000);

    // R10: the active ratio only moves at a period end
    p_ratio_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_val != ratio_act - RATIO_W'(1)) |=> $stable(ratio_act));

    // R9: the counter stays within its period
    p_cnt_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_val < ratio_act);

endmodule

bind wmask_clkdiv wmclk_checker #(
    .RATIO_W (RATIO_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ratio_act (ratio_act),
    .cnt_val   (cnt_val)
);

// File: tb/wmask_clkdiv_tb_top.sv
module wmask_clkdiv_tb_top;
    import wmclk_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  we = 4'b0000;
    logic [31:0] wdata = '0;
    logic [31:0] rdata [4];
    logic [3:0]  co;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // 0: default plus-one, 4-bit field at 0
    wmask_clkdiv #(.SHIFT(0), .WIDTH(4), .ENC(DIV_PLUS_ONE), .ZERO_BYPASS(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(we[0]), .bus_wdata(wdata),
        .bus_rdata(rdata[0]), .clk_out(co[0]));
    // 1: power-of-two, 2-bit field at 0
    wmask_clkdiv #(.SHIFT(0), .WIDTH(2), .ENC(DIV_POW2), .ZERO_BYPASS(1'b1)) dut_p2 (
        .clk(clk), .rst_n(rst_n), .bus_we(we[1]), .bus_wdata(wdata),
        .bus_rdata(rdata[1]), .clk_out(co[1]));
    // 2: one-based, 3-bit field at 4, zero not allowed
    wmask_clkdiv #(.SHIFT(4), .WIDTH(3), .ENC(DIV_ONE_BASED), .ZERO_BYPASS(1'b0)) dut_ob (
        .clk(clk), .rst_n(rst_n), .bus_we(we[2]), .bus_wdata(wdata),
        .bus_rdata(rdata[2]), .clk_out(co[2]));
    // 3: one-based, 4-bit field at 12, zero is bypass
    wmask_clkdiv #(.SHIFT(12), .WIDTH(4), .ENC(DIV_ONE_BASED), .ZERO_BYPASS(1'b1)) dut_oz (
        .clk(clk), .rst_n(rst_n), .bus_we(we[3]), .bus_wdata(wdata),
        .bus_rdata(rdata[3]), .clk_out(co[3]));

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        we[idx] = 1'b1;
        wdata   = d;
        step();
        we[idx] = 1'b0;
    endtask

    // Period and high time in input cycles, between two rising output edges.
    // Optionally writes to the block in the first cycle of the measured period.
    task automatic measure(input int idx, input bit do_wr, input logic [31:0] d,
                           output int per, output int hi);
        logic prev, cur;
        int   guard = 0;
        per = 0;
        hi  = 0;
        prev = co[idx];
        step();
        cur = co[idx];
        while (!(prev == 1'b0 && cur == 1'b1) && guard < 400) begin
            prev = cur;
            step();
            cur = co[idx];
            guard++;
        end
        if (guard >= 400) begin
            check(1'b0, "sync", 0, 1);
            return;
        end
        per = 1;
        hi  = 1;
        if (do_wr) begin
            we[idx] = 1'b1;
            wdata   = d;
        end
        prev = cur;
        step();
        we[idx] = 1'b0;
        cur = co[idx];
        while (!(prev == 1'b0 && cur == 1'b1) && per < 400) begin
            per++;
            hi += int'(cur);
            prev = cur;
            step();
            cur = co[idx];
        end
    endtask

    task automatic check_ratio(input int idx, input int exp_per, input string req);
        int per, hi;
        measure(idx, 1'b0, '0, per, hi);
        check(per == exp_per, req, per, exp_per);
        check(hi == exp_per / 2, "R9", hi, exp_per / 2);
    endtask

    task automatic check_bypass(input int idx, input string req);
        step();
        check(co[idx] == 1'b1, req, co[idx], 1);
        @(negedge clk);
        #2;
        check(co[idx] == 1'b0, req, co[idx], 0);
    endtask

    task automatic t_reset();
        for (int k = 0; k < 4; k++) begin
            check(rdata[k] == 32'h0, "R4", rdata[k], 0);
        end
        check_bypass(0, "R4");
    endtask

    task automatic t_masked_write();
        wr(0, 32'hFFFF_A5C3);
        check(rdata[0] == 32'h0000_A5C3, "R1", rdata[0], 32'hA5C3);
        wr(0, 32'h00F0_0F0F);
        check(rdata[0] == 32'h0000_A503, "R1", rdata[0], 32'hA503);
        check(rdata[0][31:16] == 16'h0, "R3", rdata[0], 32'hA503);
    endtask

    task automatic t_empty_mask();
        wr(0, 32'h0000_FFFF);
        check(rdata[0] == 32'h0000_A503, "R2", rdata[0], 32'hA503);
        // field 3 with other bits set: ratio 4 (R5, R11)
        check_ratio(0, 4, "R5");
    endtask

    task automatic t_odd_ratio();
        wr(0, 32'h000F_0006);
        check(rdata[0] == 32'h0000_A506, "R1", rdata[0], 32'hA506);
        check_ratio(0, 7, "R9");
    endtask

    task automatic t_boundary();
        int per, hi;
        measure(0, 1'b1, 32'h000F_0001, per, hi);
        check(per == 7, "R10", per, 7);
        check(hi == 3, "R10", hi, 3);
        check_ratio(0, 2, "R10");
    endtask

    task automatic t_outside_field();
        wr(0, 32'hFFF0_0000);
        check(rdata[0] == 32'h0000_0001, "R11", rdata[0], 1);
        check_ratio(0, 2, "R11");
    endtask

    task automatic t_pow2();
        wr(1, 32'h0003_0001);
        check(rdata[1] == 32'h0000_0001, "R7", rdata[1], 1);
        check_ratio(1, 2, "R7");
        wr(1, 32'h0003_0003);
        check_ratio(1, 8, "R7");
        wr(1, 32'h0003_0000);
        repeat (20) step();
        check_bypass(1, "R7");
    endtask

    task automatic t_one_based();
        wr(2, 32'h0070_0050);
        check(rdata[2] == 32'h0000_0050, "R6", rdata[2], 32'h50);
        check_ratio(2, 5, "R6");
        wr(2, 32'h0070_0000);
        check(rdata[2] == 32'h0, "R8", rdata[2], 0);
        repeat (12) step();
        check_ratio(2, 5, "R8");
        wr(2, 32'h0001_0001);
        check(rdata[2] == 32'h0000_0001, "R11", rdata[2], 1);
        check_ratio(2, 5, "R11");
    endtask

    task automatic t_zero_bypass();
        wr(3, 32'hF000_6000);
        check(rdata[3] == 32'h0000_6000, "R6", rdata[3], 32'h6000);
        check_ratio(3, 6, "R6");
        wr(3, 32'hF000_0000);
        repeat (14) step();
        check_bypass(3, "R8");
    endtask

    task automatic t_mid_reset();
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            check(rdata[k] == 32'h0, "R4", rdata[k], 0);
        end
        check_bypass(0, "R4");
        check_bypass(2, "R4");
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        step();
        t_reset();
        t_masked_write();
        t_empty_mask();
        t_odd_ratio();
        t_boundary();
        t_outside_field();
        t_pow2();
        t_one_based();
        t_zero_bypass();
        t_mid_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule